// File: doc/BRIEF.md
# LIN Break Generator and Detector

This block adds break handling to an asynchronous serial port running in LIN mode. When it receives a one-cycle generate request, it overrides the serial output with a dominant low level. The low level lasts for a programmable count of bit times, from 13 to 16. After the break, the block forces the line recessive for one guard bit and then hands the output back to the normal transmitter. If a transmit start arrives while a break or guard bit is in progress, the block holds it and passes it on once the line is free again.

On the receive side, the block counts consecutive bit-rate ticks during which the serial input is low. A low period long enough to count as a break sets a sticky detect flag. The flag drives an interrupt when that interrupt is enabled. Once the detector has fired, it stays quiet until the input has been seen high again, so a long break is reported only once. A unit clear input returns the generator, the detector and the flag to their starting state, which prepares the block for the next break. Outside LIN mode, the block neither generates nor detects breaks.

Top module: `lin_brk_unit`

## Requirements
- R1: The length code sets the break to 13, 14, 15 or 16 bit ticks for codes 0, 1, 2 and 3. `ser_out` goes low in the cycle after an accepted `gen_req` and stays low until the clock edge that samples the last of those ticks.
- R2: A `gen_req` that arrives while a break or its guard bit is in progress is ignored, and the running break keeps its original length.
- R3: After a break, `ser_out` is held high for exactly one bit tick, whatever the value of `tx_ser`. After that, `ser_out` follows `tx_ser` again.
- R4: While the generator is idle and no break is being accepted, `tx_start` passes straight through to `tx_go` in the same cycle. If `tx_start` arrives together with an accepted `gen_req`, or during a break or guard bit, it is held. The held start is then issued as a single `tx_go` pulse in the cycle after the guard bit ends.
- R5: `det_flag` rises after the clock edge that samples the 11th consecutive bit tick with `rx_in` low. Any cycle with `rx_in` high restarts the count.
- R6: After it fires, the detector does not fire again until `rx_in` has been seen high. If the flag is cleared while the input is still low, it stays 0.
- R7: A flag write with data 0 clears `det_flag`, and a flag write with data 1 has no effect. If a detection and a clearing write happen in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when `det_flag` and `irq_en` are both 1.
- R9: While `lin_mode` is 0, `gen_req` is ignored, `ser_out` follows `tx_ser`, and no break is detected.
- R10: `unit_clr` returns the generator to idle, drops any held transmit start, clears `det_flag` and restarts the detector, which is then armed even if the input is still low.
- R11: After reset, `det_flag`, `irq` and `tx_go` are 0 and `ser_out` follows `tx_ser`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_clr | input | 1 | One-cycle clear of the whole unit |
| lin_mode | input | 1 | Port is in LIN mode |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| len_sel | input | 2 | Break length code (0..3 gives 13..16 bits) |
| gen_req | input | 1 | Generate-break strobe |
| tx_ser | input | 1 | Serial data from the normal transmitter |
| tx_start | input | 1 | Transmit-start strobe from the data path |
| tx_go | output | 1 | Transmit start released to the transmitter |
| ser_out | output | 1 | Serial output line |
| rx_in | input | 1 | Serial input line (synchronous to clk) |
| flag_wr | input | 1 | Write strobe for the detect flag |
| flag_wdata | input | 1 | Write data for the detect flag (0 clears) |
| irq_en | input | 1 | Detect interrupt enable |
| det_flag | output | 1 | Sticky break-detected flag |
| irq | output | 1 | Break-detect interrupt |

## Verification
The checker evaluates the following on every cycle:
- the flag's set, clear and hold rules, including the rule that set wins over clear;
- the one-shot disarm after a detection;
- the gating of the interrupt;
- the absence of any `tx_go` pulse while the line is low;
- a recessive output on the cycle after a break ends;
- the effect of `unit_clr`.

Some behaviours can only be shown by the bench's scenarios. These are the exact break length for each code, the exact 11-tick detection threshold, the loss of a partial count when the input goes high briefly, the timing of a held transmit start, and re-detection after a unit clear while the input is still low.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_BREAK = 2'd1,
        GEN_GUARD = 2'd2
    } gen_state_e;

    // Number of low bit times for a length code.
    function automatic int unsigned brk_bits(input logic [1:0] code,
                                             input int unsigned base);
        return base + 32'(code);
    endfunction

endpackage

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
    import lin_brk_pkg::*;
#(
    parameter int unsigned LEN_BASE   = 13,
    parameter int unsigned GUARD_BITS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       lin_mode,
    input  logic       bit_tick,
    input  logic [1:0] len_sel,
    input  logic       gen_req,
    input  logic       tx_start,
    output logic       brk_active,
    output logic       guard_active,
    output logic       gen_idle,
    output logic       tx_go
);
    localparam int unsigned MAX_LEN = LEN_BASE + 3;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_BITS - 1);

    gen_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic             pend_q;
    logic             rel_q;
    logic             start_now;

    assign start_now    = (state_q == GEN_IDLE) && lin_mode && gen_req;
    assign brk_active   = (state_q == GEN_BREAK);
    assign guard_active = (state_q == GEN_GUARD);
    assign gen_idle     = (state_q == GEN_IDLE);
    assign tx_go        = rel_q | (gen_idle & tx_start & ~start_now);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= GEN_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
            pend_q  <= 1'b0;
            rel_q   <= 1'b0;
        end else begin
            rel_q <= 1'b0;
            unique case (state_q)
                GEN_IDLE: begin
                    if (start_now) begin
                        state_q <= GEN_BREAK;
                        cnt_q   <= '0;
                        last_q  <= CNT_W'(brk_bits(len_sel, LEN_BASE) - 1);
                        pend_q  <= tx_start;
                    end
                end
                GEN_BREAK: begin
                    if (tx_start) pend_q <= 1'b1;
                    if (bit_tick) begin
                        if (cnt_q == last_q) begin
                            state_q <= GEN_GUARD;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                GEN_GUARD: begin
                    if (bit_tick && cnt_q == GUARD_LAST) begin
                        state_q <= GEN_IDLE;
                        cnt_q   <= '0;
                        rel_q   <= pend_q | tx_start;
                        pend_q  <= 1'b0;
                    end else begin
                        if (tx_start) pend_q <= 1'b1;
                        if (bit_tick) cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
    parameter int unsigned DET_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic lin_mode,
    input  logic bit_tick,
    input  logic rx_in,
    output logic fire,
    output logic armed
);
    localparam int unsigned DCNT_W = $clog2(DET_BITS + 1);
    localparam logic [DCNT_W-1:0] DET_LAST = DCNT_W'(DET_BITS - 1);

    logic [DCNT_W-1:0] cnt_q;
    logic              armed_q;

    assign armed = armed_q;
    assign fire  = armed_q & lin_mode & ~rx_in & bit_tick & (cnt_q == DET_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (rx_in) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (!lin_mode) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            if (fire) armed_q <= 1'b0;
            if (cnt_q != DET_LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lin_brk_flag.sv
module lin_brk_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fire,
    input  logic wr,
    input  logic wdata,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;

    always_ff @(posedge clk) begin
        if (rst || clr)          flag_q <= 1'b0;
        else if (fire)           flag_q <= 1'b1;
        else if (wr && !wdata)   flag_q <= 1'b0;
    end

endmodule

// File: rtl/lin_brk_unit.sv
module lin_brk_unit #(
    parameter int unsigned LEN_BASE   = 13,
    parameter int unsigned GUARD_BITS = 1,
    parameter int unsigned DET_BITS   = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       unit_clr,
    input  logic       lin_mode,
    input  logic       bit_tick,
    input  logic [1:0] len_sel,
    input  logic       gen_req,
    input  logic       tx_ser,
    input  logic       tx_start,
    output logic       tx_go,
    output logic       ser_out,
    input  logic       rx_in,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    input  logic       irq_en,
    output logic       det_flag,
    output logic       irq
);
    logic brk_active;
    logic guard_active;
    logic gen_idle;
    logic fire;
    logic det_armed;

    lin_brk_gen #(.LEN_BASE(LEN_BASE), .GUARD_BITS(GUARD_BITS)) u_gen (
        .clk(clk), .rst(rst), .clr(unit_clr), .lin_mode(lin_mode),
        .bit_tick(bit_tick), .len_sel(len_sel), .gen_req(gen_req),
        .tx_start(tx_start), .brk_active(brk_active),
        .guard_active(guard_active), .gen_idle(gen_idle), .tx_go(tx_go)
    );

    lin_brk_det #(.DET_BITS(DET_BITS)) u_det (
        .clk(clk), .rst(rst), .clr(unit_clr), .lin_mode(lin_mode),
        .bit_tick(bit_tick), .rx_in(rx_in), .fire(fire), .armed(det_armed)
    );

    lin_brk_flag u_flag (
        .clk(clk), .rst(rst), .clr(unit_clr), .fire(fire), .wr(flag_wr),
        .wdata(flag_wdata), .irq_en(irq_en), .flag(det_flag), .irq(irq)
    );

    always_comb begin
        if (brk_active)        ser_out = 1'b0;
        else if (guard_active) ser_out = 1'b1;
        else                   ser_out = tx_ser;
    end

endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk (
    input logic clk,
    input logic rst,
    input logic unit_clr,
    input logic lin_mode,
    input logic flag_wr,
    input logic flag_wdata,
    input logic irq_en,
    input logic ser_out,
    input logic tx_go,
    input logic det_flag,
    input logic irq,
    input logic brk_active,
    input logic gen_idle,
    input logic fire,
    input logic det_armed
);
    assert_guard_high_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_active) && !$past(unit_clr) |-> ser_out);

    assert_no_go_in_break_R4: assert property (@(posedge clk) disable iff (rst)
        brk_active |-> !tx_go);

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        fire && !unit_clr |=> det_flag);

    assert_one_shot_R6: assert property (@(posedge clk) disable iff (rst)
        fire && !unit_clr |=> !det_armed);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        flag_wr && !flag_wdata && !fire && !unit_clr |=> !det_flag);

    assert_flag_keep_R7: assert property (@(posedge clk) disable iff (rst)
        det_flag && !(flag_wr && !flag_wdata) && !unit_clr |=> det_flag);

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(det_flag) && irq_en |-> irq);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !det_flag |-> !irq);

    assert_gen_off_R9: assert property (@(posedge clk) disable iff (rst)
        gen_idle && !lin_mode |=> gen_idle);

    assert_unit_clr_R10: assert property (@(posedge clk) disable iff (rst)
        unit_clr |=> gen_idle && !det_flag);

endmodule

bind lin_brk_unit lin_brk_chk u_chk (
    .clk(clk), .rst(rst), .unit_clr(unit_clr), .lin_mode(lin_mode),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .irq_en(irq_en),
    .ser_out(ser_out), .tx_go(tx_go), .det_flag(det_flag), .irq(irq),
    .brk_active(brk_active), .gen_idle(gen_idle), .fire(fire),
    .det_armed(det_armed)
);

// File: tb/tb_lin_brk_unit.sv
module tb_lin_brk_unit;
    logic       clk = 1'b0;
    logic       rst, unit_clr, lin_mode, bit_tick, gen_req, tx_ser, tx_start;
    logic [1:0] len_sel;
    logic       rx_in, flag_wr, flag_wdata, irq_en;
    logic       tx_go, ser_out, det_flag, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    lin_brk_unit dut (
        .clk(clk), .rst(rst), .unit_clr(unit_clr), .lin_mode(lin_mode),
        .bit_tick(bit_tick), .len_sel(len_sel), .gen_req(gen_req),
        .tx_ser(tx_ser), .tx_start(tx_start), .tx_go(tx_go),
        .ser_out(ser_out), .rx_in(rx_in), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .irq_en(irq_en), .det_flag(det_flag),
        .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0] code;
        logic [7:0] low_bits;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{code: 2'd2, low_bits: 8'd15},
        '{code: 2'd0, low_bits: 8'd13},
        '{code: 2'd3, low_bits: 8'd16},
        '{code: 2'd1, low_bits: 8'd14}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            step();
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic start_break(input logic [1:0] code);
        len_sel = code;
        gen_req = 1'b1;
        step();
        gen_req = 1'b0;
    endtask

    task automatic clear_flag();
        flag_wr = 1'b1; flag_wdata = 1'b0;
        step();
        flag_wr = 1'b0;
    endtask

    initial begin
        rst = 1'b1; unit_clr = 1'b0; lin_mode = 1'b1; bit_tick = 1'b0;
        gen_req = 1'b0; tx_ser = 1'b1; tx_start = 1'b0; len_sel = 2'd0;
        rx_in = 1'b1; flag_wr = 1'b0; flag_wdata = 1'b0; irq_en = 1'b0;
        #2;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R11 reset state
        chk("R11 flag", int'(det_flag), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R11 tx_go", int'(tx_go), 0);
        chk("R11 ser_out high", int'(ser_out), 1);
        tx_ser = 1'b0; #1;
        chk("R11 ser_out low", int'(ser_out), 0);

        // R1 / R3 table walk
        for (int i = 0; i < 4; i++) begin
            int n;
            tx_ser = 1'b0;
            start_break(VEC[i].code);
            chk("R1 low at start", int'(ser_out), 0);
            n = 0;
            while (ser_out == 1'b0 && n < 40) begin
                ticks(1);
                n++;
            end
            chk("R1 length", n, int'(VEC[i].low_bits));
            chk("R3 guard high", int'(ser_out), 1);
            ticks(1);
            chk("R3 guard one bit", int'(ser_out), 0);
        end

        // R2 request during a break is ignored
        begin
            int n;
            start_break(2'd0);
            ticks(5);
            len_sel = 2'd3;
            gen_req = 1'b1; step(); gen_req = 1'b0;
            n = 0;
            while (ser_out == 1'b0 && n < 40) begin
                ticks(1);
                n++;
            end
            chk("R2 remaining length", n, 8);
            ticks(1);
        end

        // R4 pass-through and hold
        tx_ser = 1'b1;
        tx_start = 1'b1; #1;
        chk("R4 pass through", int'(tx_go), 1);
        gen_req = 1'b1; len_sel = 2'd0; #1;
        chk("R4 held with accepted request", int'(tx_go), 0);
        step();
        gen_req = 1'b0; tx_start = 1'b0; #1;
        chk("R4 no go in break", int'(tx_go), 0);
        ticks(13);
        chk("R4 no go in guard", int'(tx_go), 0);
        bit_tick = 1'b1;
        step();
        bit_tick = 1'b0; #1;
        chk("R4 released after guard", int'(tx_go), 1);
        step();
        chk("R4 single pulse", int'(tx_go), 0);

        // R9 not in LIN mode
        lin_mode = 1'b0;
        tx_ser = 1'b1;
        start_break(2'd0);
        chk("R9 no break", int'(ser_out), 1);
        rx_in = 1'b0;
        ticks(20);
        chk("R9 no detect", int'(det_flag), 0);
        rx_in = 1'b1; step();
        lin_mode = 1'b1;

        // R5 threshold, R8 interrupt
        rx_in = 1'b0;
        ticks(10);
        chk("R5 not yet", int'(det_flag), 0);
        ticks(1);
        chk("R5 detect", int'(det_flag), 1);
        chk("R8 irq gated", int'(irq), 0);
        irq_en = 1'b1; #1;
        chk("R8 irq on", int'(irq), 1);

        // R6 no re-fire while low
        clear_flag();
        chk("R7 clear", int'(det_flag), 0);
        ticks(15);
        chk("R6 no refire", int'(det_flag), 0);
        rx_in = 1'b1; step();
        rx_in = 1'b0;
        ticks(11);
        chk("R6 rearm after high", int'(det_flag), 1);

        // R7 write 1 no effect
        flag_wr = 1'b1; flag_wdata = 1'b1; step(); flag_wr = 1'b0;
        chk("R7 write one kept", int'(det_flag), 1);
        clear_flag();
        irq_en = 1'b0;

        // R5 short high glitch restarts the count
        rx_in = 1'b1; step();
        rx_in = 1'b0; ticks(8);
        rx_in = 1'b1; step();
        rx_in = 1'b0; ticks(10);
        chk("R5 glitch restart", int'(det_flag), 0);
        ticks(1);
        chk("R5 after restart", int'(det_flag), 1);

        // R7 set beats clear
        clear_flag();
        rx_in = 1'b1; step();
        rx_in = 1'b0; ticks(10);
        bit_tick = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
        step();
        bit_tick = 1'b0; flag_wr = 1'b0;
        chk("R7 set wins", int'(det_flag), 1);

        // R10 unit clear
        tx_ser = 1'b1;
        start_break(2'd1);
        tx_start = 1'b1; step(); tx_start = 1'b0;
        ticks(2);
        unit_clr = 1'b1; step(); unit_clr = 1'b0;
        chk("R10 flag cleared", int'(det_flag), 0);
        chk("R10 output released", int'(ser_out), 1);
        ticks(10);
        chk("R10 held start dropped", int'(tx_go), 0);
        chk("R10 count restarted", int'(det_flag), 0);
        ticks(1);
        chk("R10 rearmed while low", int'(det_flag), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule